// File: doc/BRIEF.md
# Banked Memory Address Translator

The translator takes a 12-bit instruction address and the two bank-select registers it holds, and forms a flat physical word address. The erasable space holds 2,048 words, built from 8 pages of 256 words. The fixed space holds 36,864 words, built from 36 pages of 1,024 words. For each access the block classifies the address into one of five kinds: the hardware register space, always-visible erasable, the paged erasable window, always-visible fixed, or the paged fixed window. It then raises one region select and drives the physical address that the memory arrays need. The memory arrays themselves sit outside the block.

Software reaches the bank state at three fixed register addresses. One address holds the erasable page, one holds the fixed page, and one combined view holds both. All translation is combinational from the address and the stored page numbers. A write to a bank register takes effect from the next rising clock edge. The reset is asserted asynchronously, and its release is synchronised inside the block.

Top module: `bxl_translator`

## Requirements
- R1: After reset the erasable page and the fixed page are both 0. Reads of addresses octal 0003, 0004 and 0006 return 0.
- R2: Addresses octal 0010–0377 raise sel_erase, and phys_addr equals the address.
- R3: Addresses octal 0400–0777 raise sel_erase. phys_addr is the erasable page times 256, plus the address bits [7:0].
- R4: Addresses octal 2000–3777 raise sel_fixed and map onto fixed page 2, so phys_addr = 2048 + address bits [9:0]. The fixed page register has no effect on this range.
- R5: Addresses octal 4000–7777 raise sel_fixed. phys_addr is the fixed page times 1024, plus the address bits [9:0]. Address bit 10 is ignored, so octal 6000–7777 aliases octal 4000–5777.
- R6: An access to octal 4000–7777 while the fixed page is 36 or more raises err_map. That access drives phys_addr to 0 and raises no select. Page 35 is still valid.
- R7: Addresses octal 1000–1777 are unmapped. They raise err_map, drive phys_addr to 0 and raise no select, for reads and for writes.
- R8: A write anywhere in octal 2000–7777 raises err_wr_fixed and keeps sel_fixed low. It changes no bank register.
- R9: Address octal 0003 holds the erasable page in data bits [10:8]. Address octal 0004 holds the fixed page in data bits [15:10]. All other read bits are 0, and a write loads only that field.
- R10: Address octal 0006 reads the fixed page in bits [15:10] and the erasable page in bits [2:0]. A write to it loads both pages from those same fields.
- R11: Address octal 0007 always reads 0, and writes to it change nothing.
- R12: Addresses octal 0000–0007 raise sel_reg with phys_addr equal to the address, and at most one select is high at a time. When acc_valid is low, every select, error and data output is 0. A register write takes effect from the next clock edge, so the read data shown in the writing cycle is the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | The access is a write |
| acc_addr | input | 12 | Instruction address |
| acc_wdata | input | 16 | Write data for bank registers |
| sel_reg | output | 1 | Access targets the hardware register space |
| sel_erase | output | 1 | Access targets erasable memory |
| sel_fixed | output | 1 | Read access targets fixed memory |
| phys_addr | output | 16 | Physical word address within the selected space |
| reg_rdata | output | 16 | Read data of the bank registers |
| err_map | output | 1 | Unmapped address or fixed page out of range |
| err_wr_fixed | output | 1 | Write to read-only fixed memory was blocked |

## Verification
The main function is tried with addresses at both edges of every region, each with several page values. The region edges separate an off-by-one in the window decode from a wrong page shift. Fixed pages 35 and 36 pin down the range limit, and the alias address octal 7777 shows that bit 10 is dropped. The combined register is written and then read back through the two single registers, and vice versa, which exposes any swap or misplacement of the page fields. Writes to fixed space and to the zero register are each followed by a read of the combined register, which shows that those writes left the bank state untouched.

// File: rtl/bxl_pkg.sv
package bxl_pkg;
  // register-space addresses decoded by the bank register file
  localparam logic [11:0] A_EPAGE = 12'o0003;
  localparam logic [11:0] A_FPAGE = 12'o0004;
  localparam logic [11:0] A_BOTH  = 12'o0006;
  localparam logic [11:0] A_ZERO  = 12'o0007;

  // data field positions (LSB of each page field)
  localparam int EP_LSB      = 8;   // erasable page inside its own register
  localparam int FP_LSB      = 10;  // fixed page inside its own and the combined register
  localparam int EP_BOTH_LSB = 0;   // erasable page inside the combined register

  typedef enum logic [2:0] {
    RG_HWREG,
    RG_ERASE_U,
    RG_ERASE_S,
    RG_UNMAPPED,
    RG_FIXED_C,
    RG_FIXED_S
  } region_e;
endpackage

// File: rtl/bxl_rst_sync.sv
module bxl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bxl_region_decode.sv
module bxl_region_decode
  import bxl_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int EPAGE_W   = 8,
  parameter int REG_SPAN_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);
  localparam int TOP = ADDR_W - 1;

  always_comb begin
    if (addr[TOP])
      region = RG_FIXED_S;
    else if (addr[TOP-1])
      region = RG_FIXED_C;
    else if (addr[TOP-2])
      region = RG_UNMAPPED;
    else if (addr[EPAGE_W])
      region = RG_ERASE_S;
    else if (addr[EPAGE_W-1:REG_SPAN_W] == '0)
      region = RG_HWREG;
    else
      region = RG_ERASE_U;
  end
endmodule

// File: rtl/bxl_bank_regs.sv
module bxl_bank_regs
  import bxl_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int EB_W   = 3,
  parameter int FB_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [EB_W-1:0]   epage,
  output logic [FB_W-1:0]   fpage,
  output logic [DATA_W-1:0] rdata
);
  logic [EB_W-1:0] ep_q, ep_d;
  logic [FB_W-1:0] fp_q, fp_d;
  logic            ep_en, fp_en;
  logic            hit_ep, hit_fp, hit_both;

  always_comb begin
    hit_ep   = (addr == A_EPAGE);
    hit_fp   = (addr == A_FPAGE);
    hit_both = (addr == A_BOTH);
    ep_en    = wr_en && (hit_ep || hit_both);
    fp_en    = wr_en && (hit_fp || hit_both);
    ep_d     = hit_both ? wdata[EP_BOTH_LSB +: EB_W] : wdata[EP_LSB +: EB_W];
    fp_d     = wdata[FP_LSB +: FB_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ep_q <= '0;
    else if (ep_en) ep_q <= ep_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fp_q <= '0;
    else if (fp_en) fp_q <= fp_d;
  end

  always_comb begin
    rdata = '0;
    if (hit_ep) begin
      rdata[EP_LSB +: EB_W] = ep_q;
    end else if (hit_fp) begin
      rdata[FP_LSB +: FB_W] = fp_q;
    end else if (hit_both) begin
      rdata[FP_LSB +: FB_W]      = fp_q;
      rdata[EP_BOTH_LSB +: EB_W] = ep_q;
    end
  end

  assign epage = ep_q;
  assign fpage = fp_q;
endmodule

// File: rtl/bxl_phys_form.sv
module bxl_phys_form
  import bxl_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int PHYS_W      = 16,
  parameter int EB_W        = 3,
  parameter int FB_W        = 6,
  parameter int EPAGE_W     = 8,
  parameter int FPAGE_W     = 10,
  parameter int FIXED_BANKS = 36,
  parameter int COMMON_BANK = 2
) (
  input  region_e           region,
  input  logic [ADDR_W-1:0] addr,
  input  logic [EB_W-1:0]   epage,
  input  logic [FB_W-1:0]   fpage,
  output logic [PHYS_W-1:0] phys,
  output logic              bank_bad
);
  localparam logic [FB_W-1:0] FB_LIMIT  = FB_W'(FIXED_BANKS);
  localparam logic [FB_W-1:0] FB_COMMON = FB_W'(COMMON_BANK);

  always_comb begin
    bank_bad = (region == RG_FIXED_S) && (fpage >= FB_LIMIT);
    phys     = '0;
    unique case (region)
      RG_HWREG,
      RG_ERASE_U:  phys = PHYS_W'(addr[EPAGE_W-1:0]);
      RG_ERASE_S:  phys = PHYS_W'({epage, addr[EPAGE_W-1:0]});
      RG_FIXED_C:  phys = PHYS_W'({FB_COMMON, addr[FPAGE_W-1:0]});
      RG_FIXED_S:  phys = bank_bad ? '0 : PHYS_W'({fpage, addr[FPAGE_W-1:0]});
      default:     phys = '0;
    endcase
  end
endmodule

// File: rtl/bxl_translator.sv
module bxl_translator
  import bxl_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 16,
  parameter int PHYS_W      = 16,
  parameter int EB_W        = 3,
  parameter int FB_W        = 6,
  parameter int FIXED_BANKS = 36,
  parameter int COMMON_BANK = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              sel_reg,
  output logic              sel_erase,
  output logic              sel_fixed,
  output logic [PHYS_W-1:0] phys_addr,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              err_map,
  output logic              err_wr_fixed
);
  localparam int EPAGE_W    = 8;
  localparam int FPAGE_W    = 10;
  localparam int REG_SPAN_W = 3;

  logic              rst_sync_n;
  region_e           region;
  logic [EB_W-1:0]   epage;
  logic [FB_W-1:0]   fpage;
  logic [DATA_W-1:0] bank_rdata;
  logic [PHYS_W-1:0] phys_raw;
  logic              bank_bad;
  logic              is_fixed, is_erase, bank_wr;

  bxl_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  bxl_region_decode #(.ADDR_W(ADDR_W), .EPAGE_W(EPAGE_W), .REG_SPAN_W(REG_SPAN_W)) u_dec (
    .addr(acc_addr), .region(region)
  );

  bxl_bank_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .EB_W(EB_W), .FB_W(FB_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(bank_wr), .addr(acc_addr),
    .wdata(acc_wdata), .epage(epage), .fpage(fpage), .rdata(bank_rdata)
  );

  bxl_phys_form #(
    .ADDR_W(ADDR_W), .PHYS_W(PHYS_W), .EB_W(EB_W), .FB_W(FB_W),
    .EPAGE_W(EPAGE_W), .FPAGE_W(FPAGE_W),
    .FIXED_BANKS(FIXED_BANKS), .COMMON_BANK(COMMON_BANK)
  ) u_phys (
    .region(region), .addr(acc_addr), .epage(epage), .fpage(fpage),
    .phys(phys_raw), .bank_bad(bank_bad)
  );

  always_comb begin
    is_fixed     = (region == RG_FIXED_C) || (region == RG_FIXED_S);
    is_erase     = (region == RG_ERASE_U) || (region == RG_ERASE_S);
    err_map      = acc_valid && ((region == RG_UNMAPPED) || bank_bad);
    err_wr_fixed = acc_valid && acc_write && is_fixed;
    sel_reg      = acc_valid && (region == RG_HWREG);
    sel_erase    = acc_valid && is_erase;
    sel_fixed    = acc_valid && is_fixed && !acc_write && !err_map;
    bank_wr      = sel_reg && acc_write;
    phys_addr    = (acc_valid && !err_map) ? phys_raw : '0;
    reg_rdata    = sel_reg ? bank_rdata : '0;
  end
endmodule

// File: rtl/bxl_translator_chk.sv
module bxl_translator_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic        acc_write,
  input logic [11:0] acc_addr,
  input logic [15:0] acc_wdata,
  input logic        sel_reg,
  input logic        sel_erase,
  input logic        sel_fixed,
  input logic [15:0] phys_addr,
  input logic [15:0] reg_rdata,
  input logic        err_map,
  input logic        err_wr_fixed
);
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_reg, sel_erase, sel_fixed})); // R12

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!sel_reg && !sel_erase && !sel_fixed && !err_map && !err_wr_fixed && reg_rdata == 16'h0)); // R12

  AST_MAP_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    err_map |-> (phys_addr == 16'h0 && !sel_reg && !sel_erase && !sel_fixed)); // R7

  AST_WR_FIXED_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    err_wr_fixed |-> !sel_fixed); // R8

  AST_ERASE_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    sel_erase |-> (phys_addr < 16'd2048)); // R3

  AST_WINDOW_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_fixed && acc_addr[11]) |-> (phys_addr[9:0] == acc_addr[9:0] && phys_addr < 16'd36864)); // R5

  AST_RDATA_ONLY_REG: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata != 16'h0) |-> sel_reg); // R9

  AST_BOTH_TO_EPAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_addr == 12'o0006) |=>
      (!(acc_valid && acc_addr == 12'o0003) || reg_rdata[10:8] == $past(acc_wdata[2:0]))); // R10
endmodule

bind bxl_translator bxl_translator_chk i_chk (
  .clk(clk), .rst_n(rst_sync_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_addr(acc_addr), .acc_wdata(acc_wdata), .sel_reg(sel_reg),
  .sel_erase(sel_erase), .sel_fixed(sel_fixed), .phys_addr(phys_addr),
  .reg_rdata(reg_rdata), .err_map(err_map), .err_wr_fixed(err_wr_fixed)
);

// File: tb/test_bxl_translator.sv
module test_bxl_translator;
  logic        clk;
  logic        rst_n;
  logic        acc_valid;
  logic        acc_write;
  logic [11:0] acc_addr;
  logic [15:0] acc_wdata;
  logic        sel_reg, sel_erase, sel_fixed;
  logic [15:0] phys_addr;
  logic [15:0] reg_rdata;
  logic        err_map, err_wr_fixed;

  int checks;
  int fails;
  bit done;

  bxl_translator i_bxl_translator (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .sel_reg(sel_reg),
    .sel_erase(sel_erase), .sel_fixed(sel_fixed), .phys_addr(phys_addr),
    .reg_rdata(reg_rdata), .err_map(err_map), .err_wr_fixed(err_wr_fixed)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  typedef struct packed {
    logic [11:0] a;
    logic        w;
    logic [15:0] d;
    logic [2:0]  sel;   // {reg, erase, fixed}
    logic [15:0] phys;
    logic [15:0] rd;
    logic        em;
    logic        ef;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VECS [NV] = '{
    '{12'o0003, 1'b0, 16'h0000, 3'b100, 16'h0003, 16'h0000, 1'b0, 1'b0, 4'd1},  // R1
    '{12'o0004, 1'b0, 16'h0000, 3'b100, 16'h0004, 16'h0000, 1'b0, 1'b0, 4'd1},  // R1
    '{12'o0006, 1'b0, 16'h0000, 3'b100, 16'h0006, 16'h0000, 1'b0, 1'b0, 4'd1},  // R1
    '{12'o0010, 1'b0, 16'h0000, 3'b010, 16'h0008, 16'h0000, 1'b0, 1'b0, 4'd2},  // R2
    '{12'o0377, 1'b0, 16'h0000, 3'b010, 16'h00FF, 16'h0000, 1'b0, 1'b0, 4'd2},  // R2
    '{12'o0003, 1'b1, 16'h0500, 3'b100, 16'h0003, 16'h0000, 1'b0, 1'b0, 4'd12}, // R12 old value shown
    '{12'o0003, 1'b0, 16'h0000, 3'b100, 16'h0003, 16'h0500, 1'b0, 1'b0, 4'd9},  // R9
    '{12'o0400, 1'b0, 16'h0000, 3'b010, 16'h0500, 16'h0000, 1'b0, 1'b0, 4'd3},  // R3
    '{12'o0777, 1'b0, 16'h0000, 3'b010, 16'h05FF, 16'h0000, 1'b0, 1'b0, 4'd3},  // R3
    '{12'o0004, 1'b1, 16'hFFFF, 3'b100, 16'h0004, 16'h0000, 1'b0, 1'b0, 4'd9},  // R9
    '{12'o0004, 1'b0, 16'h0000, 3'b100, 16'h0004, 16'hFC00, 1'b0, 1'b0, 4'd9},  // R9
    '{12'o4000, 1'b0, 16'h0000, 3'b000, 16'h0000, 16'h0000, 1'b1, 1'b0, 4'd6},  // R6 page 63
    '{12'o0004, 1'b1, 16'h8C00, 3'b100, 16'h0004, 16'hFC00, 1'b0, 1'b0, 4'd9},  // R9 page 35
    '{12'o4000, 1'b0, 16'h0000, 3'b001, 16'h8C00, 16'h0000, 1'b0, 1'b0, 4'd5},  // R5 page 35 valid
    '{12'o7777, 1'b0, 16'h0000, 3'b001, 16'h8FFF, 16'h0000, 1'b0, 1'b0, 4'd5},  // R5 alias
    '{12'o0004, 1'b1, 16'h9000, 3'b100, 16'h0004, 16'h8C00, 1'b0, 1'b0, 4'd9},  // R9 page 36
    '{12'o5000, 1'b0, 16'h0000, 3'b000, 16'h0000, 16'h0000, 1'b1, 1'b0, 4'd6},  // R6
    '{12'o2000, 1'b0, 16'h0000, 3'b001, 16'h0800, 16'h0000, 1'b0, 1'b0, 4'd4},  // R4
    '{12'o3777, 1'b0, 16'h0000, 3'b001, 16'h0BFF, 16'h0000, 1'b0, 1'b0, 4'd4},  // R4
    '{12'o1000, 1'b0, 16'h0000, 3'b000, 16'h0000, 16'h0000, 1'b1, 1'b0, 4'd7},  // R7
    '{12'o1777, 1'b0, 16'h0000, 3'b000, 16'h0000, 16'h0000, 1'b1, 1'b0, 4'd7},  // R7
    '{12'o1000, 1'b1, 16'h1234, 3'b000, 16'h0000, 16'h0000, 1'b1, 1'b0, 4'd7},  // R7 write
    '{12'o0006, 1'b0, 16'h0000, 3'b100, 16'h0006, 16'h9005, 1'b0, 1'b0, 4'd10}, // R10
    '{12'o0006, 1'b1, 16'h1C03, 3'b100, 16'h0006, 16'h9005, 1'b0, 1'b0, 4'd10}, // R10
    '{12'o0003, 1'b0, 16'h0000, 3'b100, 16'h0003, 16'h0300, 1'b0, 1'b0, 4'd10}, // R10
    '{12'o0004, 1'b0, 16'h0000, 3'b100, 16'h0004, 16'h1C00, 1'b0, 1'b0, 4'd10}, // R10
    '{12'o0007, 1'b1, 16'hFFFF, 3'b100, 16'h0007, 16'h0000, 1'b0, 1'b0, 4'd11}, // R11
    '{12'o0006, 1'b0, 16'h0000, 3'b100, 16'h0006, 16'h1C03, 1'b0, 1'b0, 4'd11}, // R11
    '{12'o0007, 1'b0, 16'h0000, 3'b100, 16'h0007, 16'h0000, 1'b0, 1'b0, 4'd11}, // R11
    '{12'o2000, 1'b1, 16'hFFFF, 3'b000, 16'h0800, 16'h0000, 1'b0, 1'b1, 4'd8},  // R8
    '{12'o4005, 1'b1, 16'hFFFF, 3'b000, 16'h1C05, 16'h0000, 1'b0, 1'b1, 4'd8},  // R8
    '{12'o0500, 1'b1, 16'hFFFF, 3'b010, 16'h0340, 16'h0000, 1'b0, 1'b0, 4'd3},  // R3
    '{12'o0006, 1'b0, 16'h0000, 3'b100, 16'h0006, 16'h1C03, 1'b0, 1'b0, 4'd8},  // R8 state intact
    '{12'o0000, 1'b0, 16'h0000, 3'b100, 16'h0000, 16'h0000, 1'b0, 1'b0, 4'd12}  // R12
  };

  task automatic check(input string tag, input logic [2:0] es, input logic [15:0] ep,
                       input logic [15:0] er, input logic eem, input logic eef);
    logic [2:0] s;
    s = {sel_reg, sel_erase, sel_fixed};
    checks++;
    if (s !== es || phys_addr !== ep || reg_rdata !== er || err_map !== eem || err_wr_fixed !== eef) begin
      fails++;
      $display("FAIL %s addr=%o: sel=%b phys=%h rd=%h em=%b ef=%b expected sel=%b phys=%h rd=%h em=%b ef=%b",
               tag, acc_addr, s, phys_addr, reg_rdata, err_map, err_wr_fixed, es, ep, er, eem, eef);
    end
  endtask

  task automatic access(input logic [11:0] a, input logic w, input logic [15:0] d);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_write = w;
    acc_addr  = a;
    acc_wdata = d;
    #2;
  endtask

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; acc_addr = '0; acc_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].a, VECS[i].w, VECS[i].d);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].sel, VECS[i].phys,
            VECS[i].rd, VECS[i].em, VECS[i].ef);
    end

    // R12: idle cycle drives everything quiet
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; acc_addr = 12'o0006;
    #2;
    check("R12 idle", 3'b000, 16'h0000, 16'h0000, 1'b0, 1'b0);

    // R12: a write to the combined register shows the new value only in the next cycle
    access(12'o0006, 1'b1, 16'h0801);
    check("R12 same-cycle", 3'b100, 16'h0006, 16'h1C03, 1'b0, 1'b0);
    access(12'o0006, 1'b0, 16'h0000);
    check("R12 next-cycle", 3'b100, 16'h0006, 16'h0801, 1'b0, 1'b0);

    // R1: asynchronous reset clears both pages at once
    @(negedge clk) rst_n = 1'b0;
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 12'o0006;
    #2;
    check("R1 in reset", 3'b100, 16'h0006, 16'h0000, 1'b0, 1'b0);
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    acc_valid = 1'b0;
    repeat (4) @(posedge clk);
    access(12'o0400, 1'b0, 16'h0000);
    check("R1 after reset page0", 3'b010, 16'h0000, 16'h0000, 1'b0, 1'b0);
    access(12'o4000, 1'b0, 16'h0000);
    check("R1 after reset fpage0", 3'b001, 16'h0000, 16'h0000, 1'b0, 1'b0);

    @(negedge clk) acc_valid = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule